// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block counts rendered scanlines downward and raises an interrupt request to the CPU once a programmed number of visible lines has gone by. Software programs it through four write-only registers: it can load the count directly, set a reload value, start counting, or stop counting. A stop write also acknowledges a pending interrupt. The video timing logic sends a one-cycle tick once per scanline, along with the current line number. The two display-enable bits tell the block whether the background or the sprites are being drawn.

A tick advances the counter only if three conditions all hold: the line is in the visible range, at least one display layer is on, and counting is started. When such a tick finds the counter non-zero, the counter decrements. When it finds the counter at zero, the counter takes the reload value and the interrupt request goes high. The request is a level. It stays high until software writes the stop register.

Register writes and line ticks are plain control strobes with no handshake. A write is always accepted in the cycle it is presented, so there is no back-pressure. When a write and a tick arrive in the same cycle, the tick is dropped.

Top module: `scan_irq_counter`

## Requirements
- R1: Reset clears the counter, the reload value, the start flag and the interrupt request to zero.
- R2: A write with `wr_sel` = 2'b00 loads the counter with `wr_data` at the next clock edge.
- R3: A write with `wr_sel` = 2'b01 loads the reload value with `wr_data`. It does not change the counter.
- R4: A write with `wr_sel` = 2'b11 starts counting. It does not clear a pending interrupt request.
- R5: A write with `wr_sel` = 2'b10 stops counting and clears the interrupt request at the next clock edge.
- R6: A tick counts only when `line_num` is 239 or less and `bg_show` or `spr_show` is high. A tick on line 240 or above, or with both display bits low, is ignored.
- R7: A counting tick that finds the counter non-zero decrements it by one and leaves `irq` unchanged.
- R8: A counting tick that finds the counter at zero reloads it from the reload value and sets `irq`. `irq` then stays high until an R5 write.
- R9: A tick while counting is stopped leaves the counter unchanged.
- R10: When a register write and a tick arrive in the same cycle, the write takes effect and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 00 count, 01 reload, 10 stop, 11 start |
| wr_data | input | 8 | Write data |
| line_tick | input | 1 | One-cycle pulse per scanline |
| line_num | input | 9 | Current scanline number |
| bg_show | input | 1 | Background display enabled |
| spr_show | input | 1 | Sprite display enabled |
| irq | output | 1 | Level interrupt request |

## Verification
The bench checks the visibility boundary at lines 239 and 240 and a tick with both display layers off. A design with an off-by-one range compare, or one that ignores the display bits, would count too early and raise `irq` a line too soon. It checks that the request fires on the tick after the count reaches zero, not on the tick that reaches zero, and that the reload value is then used. A design that fires one tick early, or reloads from the wrong source, shifts every later `irq` edge. It also checks a write that coincides with a tick, a reload value of zero (which fires on every tick), a start write while a request is pending, and a reset in the middle of a count. Mishandling any of these leaves a stale count or drops or keeps the wrong request.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;

  typedef enum logic [1:0] {
    SEL_COUNT  = 2'b00,
    SEL_RELOAD = 2'b01,
    SEL_STOP   = 2'b10,
    SEL_START  = 2'b11
  } reg_sel_e;

  typedef struct packed {
    logic load_cnt;
    logic load_rel;
    logic stop;
    logic start;
  } strobe_t;

endpackage

// File: rtl/scan_reg_decode.sv
module scan_reg_decode
  import scan_irq_pkg::*;
(
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  output strobe_t    stb,
  output logic       any_wr
);

  always_comb begin
    stb = '0;
    if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_COUNT:  stb.load_cnt = 1'b1;
        SEL_RELOAD: stb.load_rel = 1'b1;
        SEL_STOP:   stb.stop     = 1'b1;
        default:    stb.start    = 1'b1;
      endcase
    end
  end

  assign any_wr = wr_en;

endmodule

// File: rtl/scan_line_qualify.sv
module scan_line_qualify #(
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic              line_tick,
  input  logic [LINE_W-1:0] line_num,
  input  logic              bg_show,
  input  logic              spr_show,
  input  logic              any_wr,
  output logic              step
);

  localparam logic [LINE_W-1:0] LAST_L = LINE_W'(LAST_LINE);

  logic visible;
  logic drawing;

  assign visible = (line_num <= LAST_L);
  assign drawing = bg_show | spr_show;
  // a register write in the same cycle wins; the tick is dropped
  assign step    = line_tick & visible & drawing & ~any_wr;

endmodule

// File: rtl/scan_down_counter.sv
module scan_down_counter
  import scan_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          stb,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             step,
  output logic             fire
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rel_q;
  logic             run_q;
  logic             at_zero;
  logic             advance;

  assign at_zero = (cnt_q == '0);
  assign advance = step & run_q;
  assign fire    = advance & at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (stb.load_rel) rel_q <= wr_data;
      if (stb.load_cnt) begin
        cnt_q <= wr_data;
      end else if (advance) begin
        cnt_q <= at_zero ? rel_q : (cnt_q - ONE);
      end
      if (stb.start)     run_q <= 1'b1;
      else if (stb.stop) run_q <= 1'b0;
    end
  end

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    stb.load_cnt |=> (cnt_q == $past(wr_data))); // R2
  AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (step && run_q && !at_zero && !stb.load_cnt) |=> (cnt_q == $past(cnt_q) - ONE)); // R7
  AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && run_q && at_zero && !stb.load_cnt) |=> (cnt_q == $past(rel_q))); // R8
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !stb.load_cnt) |=> $stable(cnt_q)); // R9
  AST_START_SET: assert property (@(posedge clk) disable iff (!rst_n)
    stb.start |=> run_q); // R4
  AST_STOP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    stb.stop |=> !run_q); // R5

endmodule

// File: rtl/scan_irq_flag.sv
module scan_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic ack,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (!rst_n)    irq <= 1'b0;
    else if (ack)  irq <= 1'b0;
    else if (fire) irq <= 1'b1;
  end

  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq); // R5
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(fire)); // R8

endmodule

// File: rtl/scan_irq_counter.sv
module scan_irq_counter
  import scan_irq_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              line_tick,
  input  logic [LINE_W-1:0] line_num,
  input  logic              bg_show,
  input  logic              spr_show,
  output logic              irq
);

  strobe_t stb;
  logic    any_wr;
  logic    step;
  logic    fire;

  scan_reg_decode u_dec (
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .stb    (stb),
    .any_wr (any_wr)
  );

  scan_line_qualify #(.LINE_W(LINE_W), .LAST_LINE(LAST_LINE)) u_qual (
    .line_tick (line_tick),
    .line_num  (line_num),
    .bg_show   (bg_show),
    .spr_show  (spr_show),
    .any_wr    (any_wr),
    .step      (step)
  );

  scan_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .wr_data (wr_data),
    .step    (step),
    .fire    (fire)
  );

  scan_irq_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .ack   (stb.stop),
    .irq   (irq)
  );

  AST_WR_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && line_tick && wr_sel != 2'b10 && !irq) |=> !irq); // R10
  AST_HIDDEN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_num > LINE_W'(LAST_LINE) || !(bg_show || spr_show)) |-> !step); // R6

endmodule

// File: tb/sim_scan_irq_counter.sv
module sim_scan_irq_counter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'b00;
  logic [7:0] wr_data = 8'h00;
  logic       line_tick = 1'b0;
  logic [8:0] line_num = 9'd0;
  logic       bg_show = 1'b0;
  logic       spr_show = 1'b0;
  logic       irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  scan_irq_counter u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .line_tick(line_tick), .line_num(line_num), .bg_show(bg_show),
    .spr_show(spr_show), .irq(irq)
  );

  // {we, sel, data, tick, line, bg, spr, expected irq, requirement number}
  function automatic logic [27:0] mk(input logic we, input logic [1:0] sel,
    input logic [7:0] dat, input logic tk, input logic [8:0] ln, input logic bg,
    input logic sp, input logic ex, input logic [3:0] rq);
    return {we, sel, dat, tk, ln, bg, sp, ex, rq};
  endfunction

  localparam int NV = 31;
  localparam logic [27:0] VEC [NV] = '{
    mk(1, 2'd1, 8'd1, 0, 9'd0,   0, 0, 0, 4'd3),  // R3 reload = 1
    mk(1, 2'd0, 8'd2, 0, 9'd0,   0, 0, 0, 4'd2),  // R2 count = 2
    mk(0, 2'd0, 8'd0, 1, 9'd10,  1, 0, 0, 4'd9),  // R9 stopped tick
    mk(1, 2'd3, 8'd0, 0, 9'd0,   0, 0, 0, 4'd4),  // R4 start
    mk(0, 2'd0, 8'd0, 1, 9'd10,  1, 0, 0, 4'd7),  // R7 2 -> 1
    mk(0, 2'd0, 8'd0, 1, 9'd240, 1, 1, 0, 4'd6),  // R6 line 240 ignored
    mk(0, 2'd0, 8'd0, 1, 9'd20,  0, 0, 0, 4'd6),  // R6 no display ignored
    mk(0, 2'd0, 8'd0, 1, 9'd20,  0, 1, 0, 4'd7),  // R7 1 -> 0 via sprites
    mk(0, 2'd0, 8'd0, 1, 9'd239, 1, 0, 1, 4'd8),  // R8 fire at line 239
    mk(0, 2'd0, 8'd0, 1, 9'd0,   0, 1, 1, 4'd8),  // R8 held
    mk(1, 2'd3, 8'd0, 0, 9'd0,   0, 0, 1, 4'd4),  // R4 start keeps irq
    mk(1, 2'd2, 8'd0, 0, 9'd0,   0, 0, 0, 4'd5),  // R5 stop clears
    mk(0, 2'd0, 8'd0, 1, 9'd5,   1, 0, 0, 4'd9),  // R9 stopped at zero
    mk(1, 2'd3, 8'd0, 0, 9'd0,   0, 0, 0, 4'd4),
    mk(1, 2'd1, 8'd3, 1, 9'd5,   1, 0, 0, 4'd10), // R10 write beats tick
    mk(0, 2'd0, 8'd0, 1, 9'd6,   1, 0, 1, 4'd10), // R10 count still zero
    mk(1, 2'd2, 8'd0, 0, 9'd0,   0, 0, 0, 4'd5),
    mk(1, 2'd3, 8'd0, 0, 9'd0,   0, 0, 0, 4'd4),
    mk(0, 2'd0, 8'd0, 1, 9'd1,   1, 1, 0, 4'd8),  // R8 reloaded 3 -> 2
    mk(0, 2'd0, 8'd0, 1, 9'd2,   1, 1, 0, 4'd7),
    mk(0, 2'd0, 8'd0, 1, 9'd3,   1, 1, 0, 4'd7),
    mk(0, 2'd0, 8'd0, 1, 9'd4,   1, 1, 1, 4'd8),  // R8 fire after reload
    mk(1, 2'd2, 8'd0, 0, 9'd0,   0, 0, 0, 4'd5),
    mk(1, 2'd1, 8'd0, 0, 9'd0,   0, 0, 0, 4'd3),  // R3 reload = 0
    mk(1, 2'd0, 8'd0, 0, 9'd0,   0, 0, 0, 4'd2),
    mk(1, 2'd3, 8'd0, 0, 9'd0,   0, 0, 0, 4'd4),
    mk(0, 2'd0, 8'd0, 1, 9'd7,   1, 0, 1, 4'd8),  // R8 zero reload fires
    mk(1, 2'd2, 8'd0, 0, 9'd0,   0, 0, 0, 4'd5),
    mk(1, 2'd3, 8'd0, 0, 9'd0,   0, 0, 0, 4'd4),
    mk(0, 2'd0, 8'd0, 1, 9'd8,   1, 0, 1, 4'd8),  // R8 fires every tick
    mk(1, 2'd2, 8'd0, 0, 9'd0,   0, 0, 0, 4'd5)
  };

  task automatic drive(input logic we, input logic [1:0] sel, input logic [7:0] dat,
                       input logic tk, input logic [8:0] ln, input logic bg, input logic sp);
    wr_en = we; wr_sel = sel; wr_data = dat;
    line_tick = tk; line_num = ln; bg_show = bg; spr_show = sp;
  endtask

  task automatic check(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s: irq actual %b expected %b", tag, irq, exp);
    end
  endtask

  task automatic cycle(input logic we, input logic [1:0] sel, input logic [7:0] dat,
                       input logic tk, input logic [8:0] ln, input logic bg, input logic sp);
    drive(we, sel, dat, tk, ln, bg, sp);
    @(negedge clk);
    drive(0, 2'd0, 8'd0, 0, 9'd0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, "R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, "R1 after release");

    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      string tag;
      v = VEC[i];
      cycle(v[27], v[26:25], v[24:17], v[16], v[15:7], v[6], v[5]);
      tag = $sformatf("R%0d vector %0d", v[3:0], i);
      check(v[4], tag);
    end

    // R1: reset mid-count with a pending request clears count and irq
    cycle(1, 2'd1, 8'd4, 0, 9'd0, 0, 0);
    cycle(1, 2'd0, 8'd5, 0, 9'd0, 0, 0);
    cycle(1, 2'd3, 8'd0, 0, 9'd0, 0, 0);
    cycle(0, 2'd0, 8'd0, 1, 9'd0, 1, 0);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(1'b0, "R1 irq after mid reset");
    rst_n = 1'b1;
    @(negedge clk);
    cycle(0, 2'd0, 8'd0, 1, 9'd3, 1, 0);
    check(1'b0, "R1 start flag cleared by reset");
    cycle(1, 2'd3, 8'd0, 0, 9'd0, 0, 0);
    cycle(0, 2'd0, 8'd0, 1, 9'd3, 1, 0);
    check(1'b1, "R1 count cleared by reset fires at once");
    cycle(1, 2'd2, 8'd0, 0, 9'd0, 0, 0);
    cycle(1, 2'd3, 8'd0, 0, 9'd0, 0, 0);
    cycle(0, 2'd0, 8'd0, 1, 9'd3, 1, 0);
    check(1'b1, "R1 reload cleared to zero by reset");

    finish_run();
  end

endmodule